// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to 32 pins. A simple 32-bit register bus reaches it: a byte address, a write strobe, write data, and read data returned in the same cycle. Each pin has an output data bit and a direction bit, and both drive the pad controls directly. The pad inputs pass through a two-flop synchronizer and can be read back over the bus. Output, direction and interrupt-enable bits can be changed with write-one-to-set and write-one-to-clear aliases, so software can change one pin without a read-modify-write.

Each pin also has an event detector. Three configuration bits per pin select the trigger. The sense-select bit chooses level or edge detection. The polarity bit chooses positive logic (rising edge or high level) or negative logic (falling edge or low level). The dual-edge bit, used in edge mode with positive polarity, makes both edges count. Detected events latch into a pending register that software clears by writing ones. The pending bits, gated by a per-pin enable, are ORed into a single interrupt line for a parent interrupt controller.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register is 0, pad_out, pad_oe and irq are low, and every mapped address reads 0 apart from the synchronized pad inputs.
- R2: Output data at 0x00 is read/write and drives pad_out. A write to 0x40 sets the bits written as 1 and a write to 0x44 clears them. Bits written as 0 keep their value.
- R3: Direction at 0x08 is read/write and drives pad_oe, where 1 means output. A write to 0x48 sets the bits written as 1 and a write to 0x4C clears them. No other bit changes.
- R4: Address 0x04 reads the pad inputs after a two-flop synchronizer, so a pad change appears two clock edges later. Writes to 0x04 have no effect.
- R5: The interrupt enable reads at 0x30. Only a write of ones to 0x30 (set) or to 0x34 (clear) changes it. Address 0x34 reads 0.
- R6: The pending register at 0x20 is write-one-to-clear. Writing back a value read from it clears exactly those bits.
- R7: Sense-select at 0x2C: a bit of 1 selects level detection and 0 selects edge detection. In level mode the pending bit is set on every cycle the active level is present, so a clear while the level holds does not last.
- R8: Polarity at 0x18: a bit of 0 selects a rising edge or high level, and 1 selects a falling edge or low level.
- R9: Dual-edge at 0x1C: in edge mode, a bit of 1 with polarity 0 detects both edges. With polarity 1 the bit is ignored and only falling edges count. In level mode it is ignored.
- R10: irq is the OR over pins of pending AND enable. A pin whose enable is 0 still records pending events but does not raise irq.
- R11: If a new event and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R12: Addresses outside the map read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pad_in | input | NPINS | Asynchronous pad inputs |
| pad_out | output | NPINS | Output data to pads |
| pad_oe | output | NPINS | Output enable per pad (1 = drive) |
| irq | output | 1 | Combined interrupt to the parent controller |

## Verification
The assertions check the following on every cycle: the set and clear aliases touch only the bits written as 1, the enable changes only through its two aliases, a detected event always lands in the pending register even when a clear hits it in the same cycle, and the interrupt line stays low while no pin is enabled. Other behaviour can only be shown by the bench's scenarios. These are the mapping of each polarity, sense and dual-edge combination onto actual pad waveforms, the synchronizer's two-edge delay on the input register, level re-assertion after a clear, and read-back of every register. The bench covers them with a cycle-level reference model driven by random bus traffic and pad toggles, plus directed cases.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);

  localparam logic [AW-1:0] A_OUT    = AW'('h00);
  localparam logic [AW-1:0] A_IN     = AW'('h04);
  localparam logic [AW-1:0] A_DIR    = AW'('h08);
  localparam logic [AW-1:0] A_POL    = AW'('h18);
  localparam logic [AW-1:0] A_DUAL   = AW'('h1C);
  localparam logic [AW-1:0] A_PEND   = AW'('h20);
  localparam logic [AW-1:0] A_SENSE  = AW'('h2C);
  localparam logic [AW-1:0] A_ENSET  = AW'('h30);
  localparam logic [AW-1:0] A_ENCLR  = AW'('h34);
  localparam logic [AW-1:0] A_OUTSET = AW'('h40);
  localparam logic [AW-1:0] A_OUTCLR = AW'('h44);
  localparam logic [AW-1:0] A_DIRSET = AW'('h48);
  localparam logic [AW-1:0] A_DIRCLR = AW'('h4C);

  logic [NPINS-1:0] out_q, dir_q, pol_q, dual_q, sense_q, en_q, pend_q;
  logic [NPINS-1:0] meta_q, sync_q, prev_q;
  logic [NPINS-1:0] wd, rise, fall, edge_hit, level_hit, hit, pend_clr;

  assign wd   = bus_wdata[NPINS-1:0];
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  assign edge_hit  = ~sense_q & ((rise & ~pol_q & ~dual_q) |
                                 (fall & pol_q) |
                                 ((rise | fall) & dual_q & ~pol_q));
  assign level_hit = sense_q & (sync_q ^ pol_q);
  assign hit       = edge_hit | level_hit;

  assign pend_clr = (bus_we && bus_addr == A_PEND) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      dual_q  <= '0;
      sense_q <= '0;
      en_q    <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OUT:    out_q   <= wd;
        A_DIR:    dir_q   <= wd;
        A_POL:    pol_q   <= wd;
        A_DUAL:   dual_q  <= wd;
        A_SENSE:  sense_q <= wd;
        A_ENSET:  en_q    <= en_q | wd;
        A_ENCLR:  en_q    <= en_q & ~wd;
        A_OUTSET: out_q   <= out_q | wd;
        A_OUTCLR: out_q   <= out_q & ~wd;
        A_DIRSET: dir_q   <= dir_q | wd;
        A_DIRCLR: dir_q   <= dir_q & ~wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pend_clr) | hit;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OUT:   bus_rdata[NPINS-1:0] = out_q;
      A_IN:    bus_rdata[NPINS-1:0] = sync_q;
      A_DIR:   bus_rdata[NPINS-1:0] = dir_q;
      A_POL:   bus_rdata[NPINS-1:0] = pol_q;
      A_DUAL:  bus_rdata[NPINS-1:0] = dual_q;
      A_PEND:  bus_rdata[NPINS-1:0] = pend_q;
      A_SENSE: bus_rdata[NPINS-1:0] = sense_q;
      A_ENSET: bus_rdata[NPINS-1:0] = en_q;
      default: ;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = |(pend_q & en_q);

  p_outset_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUTSET) |=>
      ((pad_out & $past(wd)) == $past(wd)) &&
      (((pad_out ^ $past(pad_out)) & ~$past(wd)) == '0));

  p_outclr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUTCLR) |=>
      ((pad_out & $past(wd)) == '0) &&
      (((pad_out ^ $past(pad_out)) & ~$past(wd)) == '0));

  p_dirset_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIRSET) |=>
      ((pad_oe & $past(wd)) == $past(wd)) &&
      (((pad_oe ^ $past(pad_oe)) & ~$past(wd)) == '0));

  p_dirclr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIRCLR) |=>
      ((pad_oe & $past(wd)) == '0) &&
      (((pad_oe ^ $past(pad_oe)) & ~$past(wd)) == '0));

  p_en_alias_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == A_ENSET || bus_addr == A_ENCLR)) |=> $stable(en_q));

  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(hit)) == $past(hit)));

  p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PEND) |=> ((pend_q & $past(wd) & ~$past(hit)) == '0));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  gpio_irq_port #(.NPINS(N), .AW(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // reference model, written from the requirements
  logic [N-1:0] m_out, m_dir, m_pol, m_dual, m_sense, m_en, m_pend;
  logic [N-1:0] m_s1, m_s2, m_prev;

  function automatic logic [N-1:0] events(logic [N-1:0] cur, logic [N-1:0] old,
      logic [N-1:0] sense, logic [N-1:0] pol, logic [N-1:0] dual);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (sense[i])       r[i] = pol[i] ? !cur[i] : cur[i];
      else if (pol[i])    r[i] = old[i] && !cur[i];
      else if (dual[i])   r[i] = cur[i] != old[i];
      else                r[i] = cur[i] && !old[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_out;
      8'h04: return m_s2;
      8'h08: return m_dir;
      8'h18: return m_pol;
      8'h1C: return m_dual;
      8'h20: return m_pend;
      8'h2C: return m_sense;
      8'h30: return m_en;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R4";
      8'h08: return "R3";
      8'h18: return "R8";
      8'h1C: return "R9";
      8'h20: return "R6";
      8'h2C: return "R7";
      8'h30, 8'h34: return "R5";
      8'h40, 8'h44: return "R2";
      8'h48, 8'h4C: return "R3";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_pol = '0; m_dual = '0; m_sense = '0;
      m_en = '0; m_pend = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
    end else begin
      logic [N-1:0] ev, clr;
      ev  = events(m_s2, m_prev, m_sense, m_pol, m_dual);
      clr = (bus_we && bus_addr == 8'h20) ? bus_wdata : '0;
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_out = bus_wdata;
          8'h08: m_dir = bus_wdata;
          8'h18: m_pol = bus_wdata;
          8'h1C: m_dual = bus_wdata;
          8'h2C: m_sense = bus_wdata;
          8'h30: m_en = m_en | bus_wdata;
          8'h34: m_en = m_en & ~bus_wdata;
          8'h40: m_out = m_out | bus_wdata;
          8'h44: m_out = m_out & ~bus_wdata;
          8'h48: m_dir = m_dir | bus_wdata;
          8'h4C: m_dir = m_dir & ~bus_wdata;
          default: ;
        endcase
      end
      m_pend = (m_pend & ~clr) | ev;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pad_in;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 pad_out", pad_out, m_out);
    check("R3 pad_oe", pad_oe, m_dir);
    check("R10 irq", {31'b0, irq}, {31'b0, |(m_pend & m_en)});
    check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
  endtask

  // one cycle: drive at negedge, compare at the next negedge
  task automatic cyc(logic we, logic [7:0] a, logic [31:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_we = 1'b0; bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [7:0] ADDRS [18] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C,
    8'h20, 8'h2C, 8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h10, 8'h24,
    8'h3C, 8'h50, 8'hFC};

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 18; k++) begin
      bus_addr = ADDRS[k];
      #0.1;
      check("R1 reset read", bus_rdata, 32'h0);
    end
    check("R1 reset pads", {pad_out, pad_oe}, 64'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2 / R3 alias directed
    cyc(1, 8'h00, 32'hF0F0_0000);
    cyc(1, 8'h40, 32'h0000_000F);
    cyc(1, 8'h44, 32'h1000_0001);
    check("R2 alias result", pad_out, 32'hE0F0_000E);
    cyc(1, 8'h48, 32'h0000_FF00);
    cyc(1, 8'h4C, 32'h0000_0F00);
    check("R3 alias result", pad_oe, 32'h0000_F000);

    // R12 / R4: writes to unmapped and input address are ignored
    cyc(1, 8'h24, 32'hFFFF_FFFF);
    cyc(1, 8'h04, 32'hFFFF_FFFF);
    cyc(0, 8'h24, 0);
    check("R12 unmapped read", bus_rdata, 32'h0);
    // R5: enable not writable through 0x34 read path; only via aliases
    cyc(0, 8'h34, 0);
    check("R5 clear alias reads 0", bus_rdata, 32'h0);

    // R4: sync delay of two edges
    pad_in = 32'h0000_0080;
    cyc(0, 8'h04, 0);
    check("R4 one edge later", bus_rdata & 32'h80, 32'h0);
    cyc(0, 8'h04, 0);
    check("R4 two edges later", bus_rdata & 32'h80, 32'h80);
    cyc(0, 8'h04, 0);
    // clear whatever rising events the step produced
    rd(8'h20, v);
    cyc(1, 8'h20, v);
    cyc(0, 8'h20, 0);
    check("R6 write-back clears", bus_rdata, 32'h0);

    // R7: level-high on pin 3, clear does not last
    cyc(1, 8'h2C, 32'h0000_0008);
    pad_in = pad_in | 32'h8;
    repeat (4) cyc(0, 8'h20, 0);
    cyc(1, 8'h20, 32'h8);
    cyc(0, 8'h20, 0);
    check("R7 level re-asserts", bus_rdata & 32'h8, 32'h8);
    // R8: low level on pin 3 -> now inactive, clear sticks
    cyc(1, 8'h18, 32'h0000_0008);
    cyc(1, 8'h20, 32'h8);
    cyc(0, 8'h20, 0);
    check("R8 low level inactive", bus_rdata & 32'h8, 32'h0);

    // R10: masked pin captures but no irq
    cyc(1, 8'h2C, 32'h0);
    cyc(1, 8'h18, 32'h0);
    rd(8'h20, v);
    cyc(1, 8'h20, v);
    pad_in = pad_in | 32'h100;
    repeat (4) cyc(0, 8'h20, 0);
    check("R10 masked captured", bus_rdata & 32'h100, 32'h100);
    check("R10 masked no irq", {31'b0, irq}, 32'h0);
    cyc(1, 8'h30, 32'h100);
    check("R10 enabled irq", {31'b0, irq}, 32'h1);
    cyc(1, 8'h34, 32'h100);

    // R9: dual edge on pin 9, falling edge detected
    cyc(1, 8'h1C, 32'h200);
    pad_in = pad_in | 32'h200;
    repeat (4) cyc(0, 8'h20, 0);
    cyc(1, 8'h20, 32'h200);
    pad_in = pad_in & ~32'h200;
    repeat (4) cyc(0, 8'h20, 0);
    check("R9 falling in dual", bus_rdata & 32'h200, 32'h200);

    // R11: event and clear in the same cycle on pin 10 (rising)
    cyc(1, 8'h20, 32'hFFFF_FFFF);
    pad_in = pad_in | 32'h400;
    cyc(0, 8'h20, 0);
    cyc(0, 8'h20, 0);
    cyc(1, 8'h20, 32'h400);
    cyc(0, 8'h20, 0);
    check("R11 event wins", bus_rdata & 32'h400, 32'h400);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = ADDRS[$urandom_range(17)];
      d = $urandom;
      if ($urandom_range(3) == 0) pad_in = pad_in ^ ($urandom & $urandom & $urandom);
      if (a == 8'h20 && $urandom_range(1) == 0) d = m_pend;
      cyc($urandom_range(2) != 0, a, d);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule